// File: doc/BRIEF.md
# Region-Based Bus Access Wait-State Timer

This block sits next to a CPU bus interface and works out how long each byte access may take. It looks at the bank and page of the access address, and at a fast-ROM enable, and picks a cost of 6, 8 or 12 master clocks. It then runs the access for that many clocks, holding the CPU back with a ready signal until the final cycle. The master clock advances in steps of two, so one cycle of `clk` stands for two master clocks. Accesses made for DMA skip the region lookup and always cost 4 master clocks.

For a CPU read, the block also gives a one-cycle strobe at the point where the data should be captured, which is four master clocks before the end of the access. A CPU write gives no strobe, because the write is issued only when its whole cost has run out. The cost of the most recent CPU access is presented on a speed output. A new access is accepted on any rising edge where both `req_valid` and `ready` are high, so accesses can follow each other with no idle cycle in between.

Only address bits 23:8 reach the block, as the 16-bit bank/page value `acc_page`. The low byte never changes the timing.

Top module: `wst_timer`

## Requirements
- R1: An access to banks 0x40 to 0x7F (acc_page[15:14] = 2'b01) costs 8 master clocks, whatever the fast-ROM input is.
- R2: An access to banks 0xC0 to 0xFF costs 6 master clocks when fast_rom is 1 at acceptance, and 8 when it is 0.
- R3: In banks 0x00 to 0x3F and 0x80 to 0xBF, the page (acc_page[7:0]) sets the cost: pages 0x00 to 0x1F and 0x60 to 0x7F cost 8, pages 0x20 to 0x3F and 0x42 to 0x5F cost 6, and pages 0x40 to 0x41 cost 12.
- R4: Pages 0x80 to 0xFF cost 8 in banks 0x00 to 0x3F. In banks 0x80 to 0xBF they cost 6 with fast_rom set and 8 without it.
- R5: Take an access accepted on an edge where req_valid and ready are both high, with a cost of N master clocks. It takes the next N/2 cycles. ready is low in the first N/2-1 of them and high in the last one. In the last cycle a new access may be accepted.
- R6: A CPU read (req_dma=0, req_write=0) raises `sample` for exactly one cycle: the cycle in which 4 master clocks of the access remain, which is cycle N/2-1 of the access.
- R7: A CPU write (req_dma=0, req_write=1) never raises `sample`, and it runs for the full cost N.
- R8: A DMA access (req_dma=1) takes 4 master clocks (2 cycles) in any region and leaves `speed` unchanged. A DMA read raises `sample` in its final cycle. A DMA write never raises it.
- R9: `speed` is 8 after reset. From the cycle after a CPU access is accepted, it shows that access's cost, and it holds that value until the next CPU access is accepted.
- R10: fast_rom is sampled only on the accepting edge. Changing it during an access changes neither that access's length nor its speed value.
- R11: After reset, while no access is in progress, ready is 1 and sample is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle equals two master clocks |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Access request; accepted when ready is high |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_dma | input | 1 | 1 for a DMA byte access with a fixed cost |
| fast_rom | input | 1 | Fast-ROM enable, sampled on acceptance |
| acc_page | input | 16 | Address bits 23:8 (bank in 15:8, page in 7:0) |
| ready | output | 1 | Low while an access is still running; high when idle and in an access's last cycle |
| speed | output | 4 | Master clocks taken by the latest CPU access |
| sample | output | 1 | Read data capture strobe |

## Verification
On every cycle, the assertions check these points: a DMA access is exactly two cycles long; speed stays unchanged while ready is low; a CPU read's strobe comes one cycle before ready rises; a write's first cycle carries no strobe; and the speed chosen for the always-8 banks and for the upper banks with fast-ROM off. The full decode table across all page bands and both bank halves, with the exact strobe position for each cost, can only be shown by the bench's scenarios. The same holds for back-to-back acceptance in the final cycle and for a fast-ROM change in the middle of an access. The bench compares all of these cycle by cycle against the expected items in its queue.

// File: rtl/wst_pkg.sv
package wst_pkg;

  // Kind of the access in flight, latched on acceptance.
  typedef enum logic [1:0] {
    ACC_CPU_RD = 2'd0,
    ACC_CPU_WR = 2'd1,
    ACC_DMA_RD = 2'd2,
    ACC_DMA_WR = 2'd3
  } acc_kind_e;

  // Region boundaries of the bank/page decode.
  localparam logic [7:0] PG_IO_LO_END   = 8'h1F;
  localparam logic [7:0] PG_FAST_A_END  = 8'h3F;
  localparam logic [7:0] PG_XSLOW_END   = 8'h41;
  localparam logic [7:0] PG_FAST_B_END  = 8'h5F;
  localparam logic [7:0] PG_SLOW_HI_END = 8'h7F;

endpackage

// File: rtl/wst_region_decode.sv
module wst_region_decode #(
  parameter int unsigned SPD_W     = 4,
  parameter int unsigned FAST_CLK  = 6,
  parameter int unsigned SLOW_CLK  = 8,
  parameter int unsigned XSLOW_CLK = 12
) (
  input  logic [7:0]       bank,
  input  logic [7:0]       page,
  input  logic             fast_en,
  output logic [SPD_W-1:0] cost
);
  import wst_pkg::*;

  localparam logic [SPD_W-1:0] C_FAST  = SPD_W'(FAST_CLK);
  localparam logic [SPD_W-1:0] C_SLOW  = SPD_W'(SLOW_CLK);
  localparam logic [SPD_W-1:0] C_XSLOW = SPD_W'(XSLOW_CLK);

  logic [SPD_W-1:0] rom_cost;   // ROM area that follows the fast-ROM enable
  logic             upper_half; // banks 0x80..0xFF
  logic             data_bank;  // banks 0x40..0x7F or 0xC0..0xFF

  assign rom_cost   = fast_en ? C_FAST : C_SLOW;
  assign upper_half = bank[7];
  assign data_bank  = bank[6];

  always_comb begin
    cost = C_SLOW;
    if (data_bank) begin
      cost = upper_half ? rom_cost : C_SLOW;
    end else if (page[7]) begin
      cost = upper_half ? rom_cost : C_SLOW;
    end else if (page <= PG_IO_LO_END) begin
      cost = C_SLOW;
    end else if (page <= PG_FAST_A_END) begin
      cost = C_FAST;
    end else if (page <= PG_XSLOW_END) begin
      cost = C_XSLOW;
    end else if (page <= PG_FAST_B_END) begin
      cost = C_FAST;
    end else if (page <= PG_SLOW_HI_END) begin
      cost = C_SLOW;
    end
  end

endmodule

// File: rtl/wst_cycle_counter.sv
module wst_cycle_counter #(
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned STEP_CLK = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] remain
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(STEP_CLK);

  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] rem_d;
  logic             rem_en;

  // Next state: a load wins; otherwise the count drains by one step per cycle.
  always_comb begin
    rem_en = load || (rem_q != '0);
    rem_d  = rem_q;
    if (load) begin
      rem_d = load_val;
    end else if (rem_q >= STEP) begin
      rem_d = rem_q - STEP;
    end else if (rem_q != '0) begin
      rem_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (rem_en) begin
      rem_q <= rem_d;
    end
  end

  assign remain = rem_q;

endmodule

// File: rtl/wst_phase_strobe.sv
module wst_phase_strobe #(
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned STEP_CLK = 2,
  parameter int unsigned LEAD_CLK = 4
) (
  input  logic [CNT_W-1:0]      remain,
  input  wst_pkg::acc_kind_e    kind,
  output logic                  ready,
  output logic                  sample
);
  import wst_pkg::*;

  localparam logic [CNT_W-1:0] STEP = CNT_W'(STEP_CLK);
  localparam logic [CNT_W-1:0] LEAD = CNT_W'(LEAD_CLK);

  logic last_or_idle;

  assign last_or_idle = (remain <= STEP);
  assign ready        = last_or_idle;

  always_comb begin
    sample = 1'b0;
    unique case (kind)
      ACC_CPU_RD: sample = (remain == LEAD);
      ACC_DMA_RD: sample = (remain == STEP);
      ACC_CPU_WR,
      ACC_DMA_WR: sample = 1'b0;
      default:    sample = 1'b0;
    endcase
  end

endmodule

// File: rtl/wst_timer.sv
module wst_timer #(
  parameter int unsigned FAST_CLK  = 6,
  parameter int unsigned SLOW_CLK  = 8,
  parameter int unsigned XSLOW_CLK = 12,
  parameter int unsigned DMA_CLK   = 4,
  parameter int unsigned LEAD_CLK  = 4,
  parameter int unsigned STEP_CLK  = 2,
  parameter int unsigned SPD_W     = $clog2(XSLOW_CLK + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_dma,
  input  logic             fast_rom,
  input  logic [15:0]      acc_page,
  output logic             ready,
  output logic [SPD_W-1:0] speed,
  output logic             sample
);
  import wst_pkg::*;

  localparam logic [SPD_W-1:0] C_SLOW = SPD_W'(SLOW_CLK);
  localparam logic [SPD_W-1:0] C_DMA  = SPD_W'(DMA_CLK);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta;
  logic rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  // Region cost for the presented address.
  logic [SPD_W-1:0] region_cost;

  wst_region_decode #(
    .SPD_W     (SPD_W),
    .FAST_CLK  (FAST_CLK),
    .SLOW_CLK  (SLOW_CLK),
    .XSLOW_CLK (XSLOW_CLK)
  ) u_decode (
    .bank    (acc_page[15:8]),
    .page    (acc_page[7:0]),
    .fast_en (fast_rom),
    .cost    (region_cost)
  );

  logic             rdy_int;
  logic             accept;
  logic [SPD_W-1:0] load_cost;
  logic [SPD_W-1:0] remain;

  assign accept    = req_valid && rdy_int && rst_q;
  assign load_cost = req_dma ? C_DMA : region_cost;

  wst_cycle_counter #(
    .CNT_W    (SPD_W),
    .STEP_CLK (STEP_CLK)
  ) u_count (
    .clk      (clk),
    .rst_n    (rst_q),
    .load     (accept),
    .load_val (load_cost),
    .remain   (remain)
  );

  // Access kind and speed registers.
  acc_kind_e        kind_q, kind_d;
  logic [SPD_W-1:0] spd_q, spd_d;
  logic             kind_en;
  logic             spd_en;

  always_comb begin
    kind_en = accept;
    kind_d  = acc_kind_e'({req_dma, req_write});
    spd_en  = accept && !req_dma;
    spd_d   = region_cost;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      kind_q <= ACC_CPU_RD;
    end else if (kind_en) begin
      kind_q <= kind_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      spd_q <= C_SLOW;
    end else if (spd_en) begin
      spd_q <= spd_d;
    end
  end

  wst_phase_strobe #(
    .CNT_W    (SPD_W),
    .STEP_CLK (STEP_CLK),
    .LEAD_CLK (LEAD_CLK)
  ) u_strobe (
    .remain (remain),
    .kind   (kind_q),
    .ready  (rdy_int),
    .sample (sample)
  );

  assign ready = rdy_int;
  assign speed = spd_q;

endmodule

// File: rtl/wst_timer_chk.sv
module wst_timer_chk #(
  parameter int unsigned SPD_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic             req_dma,
  input logic             fast_rom,
  input logic [15:0]      acc_page,
  input logic             ready,
  input logic [SPD_W-1:0] speed,
  input logic             sample
);
  logic acc;
  assign acc = req_valid && ready;

  // R1
  a_r1_data_bank_slow: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_dma && acc_page[15:14] == 2'b01) |=> (speed == SPD_W'(8)));

  // R2
  a_r2_upper_bank_slow: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_dma && acc_page[15:14] == 2'b11 && !fast_rom) |=> (speed == SPD_W'(8)));

  // R6
  a_r6_read_strobe_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !ready) |=> ready);

  // R7
  a_r7_write_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && !req_dma) |=> (!sample && !ready));

  // R8
  a_r8_dma_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_dma) |=> (!ready ##1 ready));

  // R9
  a_r9_speed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(speed));

endmodule

bind wst_timer wst_timer_chk #(.SPD_W(SPD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_dma   (req_dma),
  .fast_rom  (fast_rom),
  .acc_page  (acc_page),
  .ready     (ready),
  .speed     (speed),
  .sample    (sample)
);

// File: tb/sim_wst_timer.sv
module sim_wst_timer;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int    cyc;   // cycles in access
    int    sidx;  // cycle carrying the strobe, 0 = none
    int    spd;   // speed seen during access
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_dma, fast_rom;
  logic [15:0] acc_page;
  logic        ready, sample;
  logic [3:0]  speed;

  int   checks = 0;
  int   fails  = 0;
  exp_t q[$];
  exp_t cur;
  bit   active = 0;
  bit   started = 0;
  bit   done = 0;
  int   pos = 0;
  int   idle_spd = 8;
  int   drv_spd = 8;

  always #(CLK_PERIOD/2) clk = ~clk;

  wst_timer u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_dma(req_dma), .fast_rom(fast_rom), .acc_page(acc_page),
    .ready(ready), .speed(speed), .sample(sample)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Driver: push the expected item, present the request for one cycle.
  task automatic issue(input logic [15:0] pg, input bit wr, input bit dma, input bit fr,
                       input int spd, input string tag, input int gap, input bit flip);
    exp_t it;
    int n;
    n       = dma ? 4 : spd;
    it.cyc  = n / 2;
    it.sidx = wr ? 0 : (dma ? 2 : n / 2 - 1);
    it.spd  = dma ? drv_spd : spd;
    it.tag  = tag;
    if (!dma) drv_spd = spd;
    @(negedge clk);
    q.push_back(it);
    acc_page = pg; req_write = wr; req_dma = dma; fast_rom = fr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (flip) fast_rom = ~fr;
    repeat (n / 2 - 2 + gap) @(negedge clk);
  endtask

  // Monitor: pop on acceptance, compare every cycle.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (started) begin
        if (active) begin
          pos++;
          chk(ready === (pos == cur.cyc), {"R5 ready in ", cur.tag}, ready, pos == cur.cyc);
          chk(sample === (pos == cur.sidx), {"R6 sample in ", cur.tag}, sample, pos == cur.sidx);
          chk(speed == cur.spd, {"R9 speed in ", cur.tag}, speed, cur.spd);
          if (pos == cur.cyc) begin
            active = 0;
            idle_spd = cur.spd;
          end
        end else begin
          chk(ready === 1'b1, "R11 idle ready", ready, 1);
          chk(sample === 1'b0, "R11 idle sample", sample, 0);
          chk(speed == idle_spd, "R9 idle speed", speed, idle_spd);
        end
        if (req_valid && ready) begin
          if (q.size() == 0) begin
            chk(1'b0, "R5 unexpected acceptance", 1, 0);
          end else begin
            cur = q.pop_front();
            active = 1;
            pos = 0;
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_dma = 1'b0;
    fast_rom = 1'b0; acc_page = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(ready === 1'b1, "R11 reset ready", ready, 1);
    chk(sample === 1'b0, "R11 reset sample", sample, 0);
    chk(speed == 8, "R9 reset speed", speed, 8);
    started = 1;

    // R1 data banks
    issue(16'h7E12, 0, 0, 0, 8, "R1", 1, 0);
    issue(16'h4510, 0, 0, 1, 8, "R1", 1, 0);
    // R2 upper banks
    issue(16'hC080, 0, 0, 1, 6, "R2", 1, 0);
    issue(16'hFF00, 0, 0, 0, 8, "R2", 1, 0);
    // R3 page bands
    issue(16'h001F, 0, 0, 1, 8,  "R3", 1, 0);
    issue(16'h0020, 0, 0, 0, 6,  "R3", 1, 0);
    issue(16'h0040, 0, 0, 0, 12, "R3", 1, 0);
    issue(16'h8041, 0, 0, 1, 12, "R3", 1, 0);
    issue(16'h0042, 0, 0, 0, 6,  "R3", 1, 0);
    issue(16'h005F, 0, 0, 0, 6,  "R3", 1, 0);
    issue(16'h0060, 0, 0, 1, 8,  "R3", 1, 0);
    issue(16'hBF7F, 0, 0, 1, 8,  "R3", 1, 0);
    // R4 upper pages
    issue(16'h3F80, 0, 0, 1, 8, "R4", 1, 0);
    issue(16'h80FF, 0, 0, 1, 6, "R4", 1, 0);
    issue(16'hBF80, 0, 0, 0, 8, "R4", 1, 0);
    // R7 writes
    issue(16'h0021, 1, 0, 0, 6,  "R7", 1, 0);
    issue(16'h0040, 1, 0, 0, 12, "R7", 1, 0);
    // R8 DMA
    issue(16'h0040, 0, 1, 0, 0, "R8", 1, 0);
    issue(16'hC000, 1, 1, 1, 0, "R8", 1, 0);
    // R5 back to back
    issue(16'h0020, 0, 0, 0, 6, "R5", 0, 0);
    issue(16'h7E00, 1, 0, 0, 8, "R5", 0, 0);
    issue(16'h4300, 0, 1, 0, 0, "R5", 0, 0);
    issue(16'h0041, 0, 0, 0, 12, "R5", 1, 0);
    // R10 fast-ROM change during the access
    issue(16'hC123, 0, 0, 1, 6, "R10", 1, 1);
    issue(16'h9F90, 0, 0, 0, 8, "R10", 1, 1);

    repeat (4) @(negedge clk);
    #2;
    chk(q.size() == 0, "R5 all items consumed", q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule